// File: doc/BRIEF.md
# Serial Channel Register Bank with Hidden Flag Shadow and Readback Aliases

This block is the processor-side register file of one serial controller channel. It stores the write-only control registers the bank owns (3, 4, 5, 7, the hidden 7 shadow, 10 and 15) and takes byte writes and reads over an 8-bit bus with a 4-bit register select. A mode bit in register 15 changes where a write to address 7 lands. When it is clear, the write goes to the ordinary flag-pattern register. When it is set, the write goes to a hidden shadow register that holds extra control bits.

A second bit, bit 6 of the shadow, opens a readback path. It only counts while the register 15 mode bit is also set. While the path is open, write-only registers can be read through borrowed read addresses. When it is closed, those addresses return the normal read data that the channel supplies on `rr_norm`, or zero where no read register exists. The bank also sends three enable flags to the rest of the channel: status-queue enhancement, framed-mode enhancements and extended readback.

Top module: `chan_regbank`

## Requirements
- R1: After a synchronous reset every stored register reads back as 0x00 and `fifo_en`, `hdlc_en` and `xrd_en` are 0.
- R2: While register 15 bit 0 is 0, a write to address 7 updates `flag_pat` and leaves the shadow register unchanged.
- R3: While register 15 bit 0 is 1, a write to address 7 updates the shadow register and leaves `flag_pat` unchanged.
- R4: While `xrd_en` is 1, a read at address 9 returns register 3.
- R5: While `xrd_en` is 1, a read at address 11 returns register 10.
- R6: While `xrd_en` is 1, a read at address 14 returns the shadow register.
- R7: While `xrd_en` is 1, reads at addresses 4 and 5 return registers 4 and 5.
- R8: `xrd_en` is 1 only when register 15 bit 0 and shadow bit 6 are both 1. Shadow bit 6 has no effect while register 15 bit 0 is 0.
- R9: `fifo_en` equals register 15 bit 2 and `hdlc_en` equals register 15 bit 0, and these two bits are independent of each other.
- R10: While `xrd_en` is 0, a read at address 9 returns 0x00 and a read at any other address returns `rr_norm`. This also holds for addresses 4, 5, 11 and 14.
- R11: Each enable flag takes its new value on the clock edge that samples the write which changes it.
- R12: If `wr_en` and `rd_en` are both 1 in the same cycle, the write takes effect and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rr_norm | input | 8 | Normal read data supplied by the channel for `addr` |
| rdata | output | 8 | Read data, combinational |
| flag_pat | output | 8 | Ordinary flag-pattern register |
| fifo_en | output | 1 | Status-queue enhancement enable |
| hdlc_en | output | 1 | Framed-mode enhancements enable |
| xrd_en | output | 1 | Extended readback active |

## Verification
Two events can fall in the same cycle: a write that opens or closes the readback path, and a read that the path decides. The bench provokes this in two ways. It places reads of the alias addresses right before and right after writes to register 15 and address 7. It also drives both strobes in one cycle. A read is judged against a bench model that uses the register state before the edge. The collision cycle must give 0x00 on `rdata`, and the write from that cycle must still show in later reads and flags.

// File: rtl/chan_regbank.sv
module chan_regbank #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rr_norm,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] flag_pat,
  output logic          fifo_en,
  output logic          hdlc_en,
  output logic          xrd_en
);
  localparam int HDLC_BIT = 0;
  localparam int FIFO_BIT = 2;
  localparam int XRD_BIT  = 6;

  logic [DW-1:0] r3, r4, r5, r7, r7s, r10, r15;

  always_ff @(posedge clk) begin
    if (rst) begin
      r3 <= '0; r4 <= '0; r5 <= '0; r7 <= '0;
      r7s <= '0; r10 <= '0; r15 <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(3):  r3  <= wdata;
        AW'(4):  r4  <= wdata;
        AW'(5):  r5  <= wdata;
        AW'(7):  if (r15[HDLC_BIT]) r7s <= wdata; else r7 <= wdata;
        AW'(10): r10 <= wdata;
        AW'(15): r15 <= wdata;
        default: ;
      endcase
    end
  end

  assign hdlc_en  = r15[HDLC_BIT];
  assign fifo_en  = r15[FIFO_BIT];
  assign xrd_en   = r15[HDLC_BIT] & r7s[XRD_BIT];
  assign flag_pat = r7;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = rr_norm;
    if (xrd_en) begin
      case (addr)
        AW'(4):  rd_mux = r4;
        AW'(5):  rd_mux = r5;
        AW'(9):  rd_mux = r3;
        AW'(11): rd_mux = r10;
        AW'(14): rd_mux = r7s;
        default: ;
      endcase
    end else if (addr == AW'(9)) begin
      rd_mux = '0;
    end
  end

  assign rdata = (rd_en && !wr_en) ? rd_mux : '0;
endmodule

module chan_regbank_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] flag_pat,
  input logic          fifo_en,
  input logic          hdlc_en,
  input logic          xrd_en
);
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!fifo_en && !hdlc_en && !xrd_en && flag_pat == '0));

  a_r3_shadow_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(7) && hdlc_en) |=> $stable(flag_pat));

  a_r2_flag_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(7) && !hdlc_en) |=> flag_pat == $past(wdata));

  a_r8_xrd_needs_hdlc: assert property (@(posedge clk) disable iff (rst)
    xrd_en |-> hdlc_en);

  a_r11_flags_follow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(15)) |=> (hdlc_en == $past(wdata[0]) && fifo_en == $past(wdata[2])));

  a_r12_collide_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |-> rdata == '0);
endmodule

bind chan_regbank chan_regbank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .flag_pat(flag_pat), .fifo_en(fifo_en),
  .hdlc_en(hdlc_en), .xrd_en(xrd_en)
);

// File: tb/chan_regbank_bench.sv
module chan_regbank_bench;
  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rr_norm = 0;
  logic [7:0] rdata, flag_pat;
  logic fifo_en, hdlc_en, xrd_en;

  int checks = 0, errors = 0;
  logic [7:0] m3, m4, m5, m7, m7s, m10, m15;

  chan_regbank u_chan_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rr_norm(rr_norm), .rdata(rdata), .flag_pat(flag_pat),
    .fifo_en(fifo_en), .hdlc_en(hdlc_en), .xrd_en(xrd_en)
  );

  always #5 clk = ~clk;

  function automatic logic m_xrd();
    return m15[0] & m7s[6];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a, input logic [7:0] nrm);
    if (m_xrd()) begin
      case (a)
        4'd4: return m4;
        4'd5: return m5;
        4'd9: return m3;
        4'd11: return m10;
        4'd14: return m7s;
        default: return nrm;
      endcase
    end
    if (a == 4'd9) return 8'h00;
    return nrm;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    chk(req, {5'd0, fifo_en, hdlc_en, xrd_en}, {5'd0, m15[2], m15[0], m_xrd()});
    chk(req, flag_pat, m7);
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd3: m3 = d;
      4'd4: m4 = d;
      4'd5: m5 = d;
      4'd7: if (m15[0]) m7s = d; else m7 = d;
      4'd10: m10 = d;
      4'd15: m15 = d;
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic also_rd);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; rd_en = also_rd; rr_norm = 8'($urandom);
    #2;
    if (also_rd) chk("R12 collide", rdata, 8'h00);
    @(posedge clk); #1;
    model_write(a, d);
    wr_en = 0; rd_en = 0;
    check_flags("R11 flags after write");
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1; rr_norm = 8'($urandom);
    #2;
    chk(req, rdata, exp_rd(a, rr_norm));
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m3 = 0; m4 = 0; m5 = 0; m7 = 0; m7s = 0; m10 = 0; m15 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check_flags("R1 reset flags");
    do_read(4'd9, "R1 reset read 9");
    do_read(4'd14, "R10 alias closed");
    do_write(4'd3, 8'hA3, 0);
    do_write(4'd4, 8'hB4, 0);
    do_write(4'd5, 8'hC5, 0);
    do_write(4'd10, 8'hDA, 0);
    do_write(4'd7, 8'h7E, 0);
    chk("R2 flag write", flag_pat, 8'h7E);
    do_write(4'd7, 8'h40, 0);
    chk("R8 shadow bit6 ignored", {7'd0, xrd_en}, 8'h00);
    chk("R2 flag write", flag_pat, 8'h40);
    do_read(4'd4, "R10 addr4 closed");
    do_write(4'd15, 8'h04, 0);
    chk("R9 fifo only", {6'd0, fifo_en, hdlc_en}, 8'h02);
    do_write(4'd15, 8'h01, 0);
    chk("R9 hdlc only", {6'd0, fifo_en, hdlc_en}, 8'h01);
    do_write(4'd7, 8'h00, 0);
    chk("R3 flag kept", flag_pat, 8'h40);
    do_read(4'd14, "R10 closed with hdlc");
    do_write(4'd7, 8'h45, 0);
    chk("R8 both bits", {7'd0, xrd_en}, 8'h01);
    do_read(4'd9, "R4 read 9");
    do_read(4'd11, "R5 read 11");
    do_read(4'd14, "R6 read 14");
    do_read(4'd4, "R7 read 4");
    do_read(4'd5, "R7 read 5");
    do_read(4'd2, "R10 normal addr");
    do_write(4'd3, 8'h33, 1);
    do_read(4'd9, "R12 write landed");
    do_write(4'd15, 8'h05, 0);
    chk("R9 both", {6'd0, fifo_en, hdlc_en}, 8'h03);
    do_write(4'd15, 8'h04, 0);
    chk("R8 hdlc off masks", {7'd0, xrd_en}, 8'h00);
    do_read(4'd9, "R10 read 9 zero");
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      int pick = $urandom_range(0, 9);
      case (pick)
        0: a = 4'd3; 1: a = 4'd4; 2: a = 4'd5; 3: a = 4'd7; 4: a = 4'd9;
        5: a = 4'd10; 6: a = 4'd11; 7: a = 4'd14; 8: a = 4'd15;
        default: a = 4'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0, 1: do_write(a, 8'($urandom), 0);
        2: do_write(a, 8'($urandom), 1);
        default: do_read(a, "R4 R5 R6 R7 R10 random read");
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule